// File: doc/BRIEF.md
# Color Palette Host Access Port

This block gives an 8-bit host bus access to a 256-entry color lookup table. Each entry is 24 bits wide. A 4-bit register-select code picks the register. Single-cycle read and write strobes act on the selected register. A write and a read direction each keep their own entry address and their own red/green/blue byte position. The host loads an address, then moves whole color triples through one data port one byte at a time. The address advances once per completed triple and wraps from the last entry to entry 0.

A second, independent lookup port serves the display. A display index is ANDed with a per-bit read mask and looks up the table. The result is registered and leaves the block one cycle later. A narrow (6-bit) data mode can be selected by an input pin or forced by a mode register. In that mode the host reads back only the low six bits of each stored byte. The display port moves those six bits to the top of each color channel. The table always keeps all eight written bits.

Top module: `clut_host_port`

## Requirements
- R1: Register-select codes: 0x0 is the write address, 0x1 the palette data port, 0x2 the display read mask and 0x3 the read address. 0x4 is the mode register. A host read of any of these returns its current value on `host_rdata` in the cycle after the read strobe. Other codes read as 0. When both strobes are high together, only the write is performed.
- R2: After the write address is loaded, three data-port writes supply red, green and blue in that order. The whole entry is updated only when the blue byte is written. Red is held in bits 23:16, green in 15:8 and blue in 7:0. The write address advances by one after the blue byte, and only then.
- R3: After the read address is loaded, three data-port reads return the red, green and blue bytes of that entry. The read address advances by one after the blue read, and only then.
- R4: Both addresses wrap from 255 to 0.
- R5: Loading either address puts that direction's byte position back to red. The byte positions of the two directions are independent of each other.
- R6: In narrow mode a data-port read returns the stored byte with bits 7:6 forced to 0. All eight written bits stay stored, and a later read in wide mode returns them.
- R7: In narrow mode each display color channel is the stored bits 5:0 moved to bits 7:2, with bits 1:0 zero. In wide mode the stored channel is passed through unchanged.
- R8: The width comes from `wide_pin` (1 = 8-bit) while mode-register bit 2 is 0. When bit 2 is 1, the pin is ignored and mode-register bit 3 selects the width (1 = 8-bit). The mode register resets to 0x00.
- R9: The display index is ANDed bit by bit with the read mask before the lookup. The mask resets to 0xFF.
- R10: `disp_rgb` shows the entry addressed by `disp_idx` one clock after that index is presented. If the host completes a write to the same entry at the same edge, the previous content is shown.
- R11: After reset both addresses are 0, both byte positions are red, and `host_rdata` and `disp_rgb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 4 | Register-select code |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| wide_pin | input | 1 | Width select pin, 1 = 8-bit |
| disp_idx | input | 8 | Display-side lookup index |
| disp_rgb | output | 24 | Display color {red, green, blue}, registered |

## Verification
On every cycle the assertions check several properties. Both byte positions stay among the three legal states. Each address moves only on a blue byte, and then by exactly one with wrap. An address load returns the byte position to red and captures the written value. Narrow-mode output has zero pad bits on both the host and the display side. The bench scenarios show the behaviours that need stored content. These are whole-table write and readback, mask folding of the display index, survival of the top bits across a mode change, pin-versus-register width selection, and the old-data result on a same-edge write and lookup.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam logic [3:0] SEL_WADDR = 4'h0;
  localparam logic [3:0] SEL_DATA  = 4'h1;
  localparam logic [3:0] SEL_MASK  = 4'h2;
  localparam logic [3:0] SEL_RADDR = 4'h3;
  localparam logic [3:0] SEL_MODE  = 4'h4;

  localparam int OVR_BIT   = 2;  // mode register: pin override enable
  localparam int WIDTH_BIT = 3;  // mode register: forced width, 1 = wide
  localparam int PAD_W     = 2;  // bits dropped by the narrow mode

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq import clut_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output phase_e            phase_o,
  output logic              last_o
);
  // the triple completes when the blue byte is stepped
  assign last_o = step_i && (phase_o == PH_BLU);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o  <= '0;
      phase_o <= PH_RED;
    end else if (load_i) begin
      addr_o  <= load_val_i;
      phase_o <= PH_RED;
    end else if (step_i) begin
      case (phase_o)
        PH_RED:  phase_o <= PH_GRN;
        PH_GRN:  phase_o <= PH_BLU;
        default: phase_o <= PH_RED;
      endcase
      if (last_o) addr_o <= addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [WORD_W-1:0] host_word_o,
  input  logic [ADDR_W-1:0] disp_addr_i,
  output logic [WORD_W-1:0] disp_word_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign host_word_o = mem[host_addr_i];
  assign disp_word_o = mem[disp_addr_i];
endmodule

// File: rtl/clut_align.sv
module clut_align import clut_pkg::*; #(
  parameter int CH_W = 8,
  parameter int N_CH = 3
) (
  input  logic                 wide_i,
  input  logic [N_CH*CH_W-1:0] word_i,
  output logic [N_CH*CH_W-1:0] word_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [CH_W-1:0] raw;
    assign raw = word_i[c*CH_W +: CH_W];
    assign word_o[c*CH_W +: CH_W] =
      wide_i ? raw : {raw[CH_W-PAD_W-1:0], {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port import clut_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int CH_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           host_sel,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [CH_W-1:0]      host_wdata,
  output logic [CH_W-1:0]      host_rdata,
  input  logic                 wide_pin,
  input  logic [ADDR_W-1:0]    disp_idx,
  output logic [3*CH_W-1:0]    disp_rgb
);
  localparam int WORD_W = 3 * CH_W;

  logic [CH_W-1:0]   mode_q;
  logic [ADDR_W-1:0] mask_q;
  logic [CH_W-1:0]   hold_red, hold_grn;

  // named events shared with the checker
  logic   eff_wide, wr_go, rd_go;
  logic   data_wr, data_rd, load_w, load_r;
  logic   wr_commit, rd_advance;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  phase_e wr_phase, rd_phase;
  logic [WORD_W-1:0] host_word, disp_word, disp_aligned;

  assign eff_wide = mode_q[OVR_BIT] ? mode_q[WIDTH_BIT] : wide_pin;
  assign wr_go    = host_wr;
  assign rd_go    = host_rd && !host_wr;
  assign data_wr  = wr_go && (host_sel == SEL_DATA);
  assign data_rd  = rd_go && (host_sel == SEL_DATA);
  assign load_w   = wr_go && (host_sel == SEL_WADDR);
  assign load_r   = wr_go && (host_sel == SEL_RADDR);

  function automatic logic [CH_W-1:0] pick_byte(logic [WORD_W-1:0] w, phase_e p);
    case (p)
      PH_RED:  return w[3*CH_W-1 -: CH_W];
      PH_GRN:  return w[2*CH_W-1 -: CH_W];
      default: return w[CH_W-1:0];
    endcase
  endfunction

  function automatic logic [CH_W-1:0] host_view(logic [CH_W-1:0] b, logic wide);
    return wide ? b : {{PAD_W{1'b0}}, b[CH_W-PAD_W-1:0]};
  endfunction

  clut_seq #(.ADDR_W(ADDR_W)) u_wseq (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .load_val_i(host_wdata[ADDR_W-1:0]),
    .step_i(data_wr), .addr_o(wr_addr), .phase_o(wr_phase), .last_o(wr_commit)
  );

  clut_seq #(.ADDR_W(ADDR_W)) u_rseq (
    .clk(clk), .rst_n(rst_n), .load_i(load_r), .load_val_i(host_wdata[ADDR_W-1:0]),
    .step_i(data_rd), .addr_o(rd_addr), .phase_o(rd_phase), .last_o(rd_advance)
  );

  clut_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .we_i(wr_commit), .waddr_i(wr_addr),
    .wdata_i({hold_red, hold_grn, host_wdata}),
    .host_addr_i(rd_addr), .host_word_o(host_word),
    .disp_addr_i(disp_idx & mask_q), .disp_word_o(disp_word)
  );

  clut_align #(.CH_W(CH_W), .N_CH(3)) u_align (
    .wide_i(eff_wide), .word_i(disp_word), .word_o(disp_aligned)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      mask_q   <= '1;
      hold_red <= '0;
      hold_grn <= '0;
    end else if (wr_go) begin
      if (host_sel == SEL_MODE) mode_q <= host_wdata;
      if (host_sel == SEL_MASK) mask_q <= host_wdata[ADDR_W-1:0];
      if (data_wr && wr_phase == PH_RED) hold_red <= host_wdata;
      if (data_wr && wr_phase == PH_GRN) hold_grn <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (rd_go) begin
      case (host_sel)
        SEL_WADDR: host_rdata <= CH_W'(wr_addr);
        SEL_DATA:  host_rdata <= host_view(pick_byte(host_word, rd_phase), eff_wide);
        SEL_MASK:  host_rdata <= CH_W'(mask_q);
        SEL_RADDR: host_rdata <= CH_W'(rd_addr);
        SEL_MODE:  host_rdata <= mode_q;
        default:   host_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) disp_rgb <= '0;
    else        disp_rgb <= disp_aligned;
  end
endmodule

// File: rtl/clut_host_port_chk.sv
module clut_host_port_chk import clut_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int CH_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        host_sel,
  input logic              host_wr,
  input logic              host_rd,
  input logic [CH_W-1:0]   host_wdata,
  input logic [CH_W-1:0]   host_rdata,
  input logic [3*CH_W-1:0] disp_rgb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        wr_phase,
  input logic [1:0]        rd_phase,
  input logic              eff_wide
);
  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_phase != 2'd3) && (rd_phase != 2'd3));

  assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == SEL_DATA && wr_phase == 2'd2)
      |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));

  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == SEL_DATA && wr_phase != 2'd2) |=> $stable(wr_addr));

  // R4 wrap is covered by the width-cast comparison below
  assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_sel == SEL_DATA && rd_phase == 2'd2)
      |=> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));

  assert_load_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == SEL_WADDR)
      |=> (wr_phase == 2'd0) && (wr_addr == $past(host_wdata[ADDR_W-1:0])));

  assert_narrow_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_sel == SEL_DATA && !eff_wide)
      |=> host_rdata[CH_W-1 -: PAD_W] == '0);

  assert_narrow_display_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_wide |=> (disp_rgb[PAD_W-1:0] == '0) &&
                  (disp_rgb[CH_W +: PAD_W] == '0) &&
                  (disp_rgb[2*CH_W +: PAD_W] == '0));
endmodule

bind clut_host_port clut_host_port_chk #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .disp_rgb(disp_rgb), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .wr_phase(wr_phase), .rd_phase(rd_phase), .eff_wide(eff_wide)
);

// File: tb/clut_host_port_tb.sv
module clut_host_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_sel = 4'h0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        wide_pin = 1'b1;
  logic [7:0]  disp_idx = 8'h00;
  logic [23:0] disp_rgb;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [23:0] model [256];

  always #4 clk = ~clk;

  clut_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .wide_pin(wide_pin), .disp_idx(disp_idx), .disp_rgb(disp_rgb)
  );

  function automatic logic [23:0] pattern(int i);
    logic [7:0] r = 8'(i ^ 8'hA5);
    logic [7:0] g = 8'(i * 7 + 3);
    logic [7:0] b = 8'(255 - i);
    return {r, g, b};
  endfunction

  function automatic logic [7:0] chan(logic [23:0] w, int k);
    return w[23 - 8*k -: 8];
  endfunction

  function automatic logic [7:0] rb_model(logic [7:0] b, bit wide);
    return wide ? b : (b % 8'd64);
  endfunction

  function automatic logic [23:0] disp_model(logic [23:0] w, bit wide);
    logic [23:0] o;
    for (int k = 0; k < 3; k++) o[8*k +: 8] = wide ? w[8*k +: 8] : 8'(w[8*k +: 8] * 4);
    return o;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [3:0] s, logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(logic [3:0] s, output logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic read_entry(string req, int idx, bit wide);
    logic [7:0] v;
    hwrite(4'h3, 8'(idx));
    for (int k = 0; k < 3; k++) begin
      hread(4'h1, v);
      check(req, 32'(v), 32'(rb_model(chan(model[idx], k), wide)));
    end
  endtask

  task automatic disp_sweep(string req, logic [7:0] mask, bit wide);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      disp_idx = 8'(i);
      @(negedge clk);
      check(req, 32'(disp_rgb), 32'(disp_model(model[i & int'(mask)], wide)));
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rdata", 32'(host_rdata), 32'h0);
    check("R11 disp", 32'(disp_rgb), 32'h0);
    rst_n = 1'b1;
    hread(4'h0, v); check("R11 waddr", 32'(v), 32'h0);
    hread(4'h3, v); check("R11 raddr", 32'(v), 32'h0);
    hread(4'h2, v); check("R9 mask reset", 32'(v), 32'hFF);
    hread(4'h4, v); check("R8 mode reset", 32'(v), 32'h0);
    hread(4'h7, v); check("R1 unused code", 32'(v), 32'h0);

    // R2 fill the whole table from entry 0
    hwrite(4'h0, 8'h00);
    for (int i = 0; i < 256; i++) begin
      model[i] = pattern(i);
      for (int k = 0; k < 3; k++) hwrite(4'h1, chan(model[i], k));
    end
    hread(4'h0, v); check("R4 write wrap", 32'(v), 32'h0);

    // R3 whole-table readback through one address load
    hwrite(4'h3, 8'h00);
    for (int i = 0; i < 256; i++)
      for (int k = 0; k < 3; k++) begin
        hread(4'h1, v);
        check("R3 readback", 32'(v), 32'(chan(model[i], k)));
      end
    hread(4'h3, v); check("R4 read wrap", 32'(v), 32'h0);

    // R2 partial triple leaves address and entry alone
    hwrite(4'h0, 8'd10);
    hwrite(4'h1, 8'h11); hwrite(4'h1, 8'h22);
    hread(4'h0, v); check("R2 no step mid-triple", 32'(v), 32'd10);
    // R5 reload restarts at red
    hwrite(4'h0, 8'd20);
    hwrite(4'h1, 8'h31); hwrite(4'h1, 8'h42); hwrite(4'h1, 8'h53);
    model[20] = 24'h314253;
    hread(4'h0, v); check("R2 step after blue", 32'(v), 32'd21);
    read_entry("R2 untouched entry", 10, 1'b1);
    read_entry("R5 restarted triple", 20, 1'b1);

    // R5 read side restart, independent of writes
    hwrite(4'h3, 8'd5);
    hread(4'h1, v); check("R5 red of 5", 32'(v), 32'(chan(model[5], 0)));
    hwrite(4'h3, 8'd7);
    hread(4'h1, v); check("R5 red after reload", 32'(v), 32'(chan(model[7], 0)));
    hread(4'h1, v); check("R5 green after reload", 32'(v), 32'(chan(model[7], 1)));

    // R10 display sweep, R9 mask folding
    disp_sweep("R10 display wide", 8'hFF, 1'b1);
    hwrite(4'h2, 8'h0F);
    hread(4'h2, v); check("R1 mask readback", 32'(v), 32'h0F);
    disp_sweep("R9 masked display", 8'h0F, 1'b1);
    hwrite(4'h2, 8'hFF);

    // R6, R7 narrow mode via pin
    wide_pin = 1'b0;
    read_entry("R6 narrow readback", 200, 1'b0);
    read_entry("R6 narrow readback", 20, 1'b0);
    disp_sweep("R7 narrow display", 8'hFF, 1'b0);

    // R8 register override beats the pin
    hwrite(4'h4, 8'h0C);
    hread(4'h4, v); check("R1 mode readback", 32'(v), 32'h0C);
    read_entry("R6 bits kept, R8 forced wide", 200, 1'b1);
    @(negedge clk); disp_idx = 8'd200;
    @(negedge clk); check("R8 forced wide display", 32'(disp_rgb), 32'(model[200]));
    wide_pin = 1'b1;
    hwrite(4'h4, 8'h04);
    read_entry("R8 forced narrow", 33, 1'b0);
    @(negedge clk); disp_idx = 8'd33;
    @(negedge clk); check("R8 forced narrow display", 32'(disp_rgb), 32'(disp_model(model[33], 1'b0)));
    hwrite(4'h4, 8'h00);

    // R10 same-edge commit and lookup return old data
    hwrite(4'h0, 8'd40);
    hwrite(4'h1, 8'hDE); hwrite(4'h1, 8'hAD);
    @(negedge clk);
    disp_idx = 8'd40; host_sel = 4'h1; host_wdata = 8'hBE; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    check("R10 old data on collision", 32'(disp_rgb), 32'(model[40]));
    model[40] = 24'hDEADBE;
    @(negedge clk);
    check("R10 new data next cycle", 32'(disp_rgb), 32'(model[40]));

    // R1 simultaneous strobes: only the write acts
    hwrite(4'h3, 8'd60);
    @(negedge clk);
    host_sel = 4'h1; host_wdata = 8'h77; host_wr = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    hread(4'h1, v); check("R1 read ignored with write", 32'(v), 32'(chan(model[60], 0)));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule